// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a memory-mapped watchdog. A programmable prescaler turns the reference clock into a slow tick, and a tick counter runs up towards a terminal count that software loads. When the count is reached, the block raises a system reset request, unless software restarts the count first by writing to a dedicated restart register. A reset request can be issued only while the watchdog is armed, and it is gated separately from the counting enable. Software therefore can let the watchdog count without reset power.

The block has four 32-bit registers, with register k at byte offset 4·k:

| Offset | Register |
|--------|----------|
| 0x0 | Control word |
| 0x4 | Spare read/write word |
| 0x8 | Terminal count, in ticks |
| 0xC | Restart register |

A write of any value to the restart register clears the tick counter. A read of the restart register returns the current tick count.

For a 1 ms tick from a 24 MHz reference, software loads 24000 into the divider field. For a timeout of N seconds, with N from 1 to 8, it loads N·1000 into the terminal count.

Top module: `wdog_top`

## Requirements
- R1: After a synchronous reset, all registers read zero and `sys_rst_req` is low.
- R2: Control bits behave as follows:
  - Bit 25 enables the divider and bit 24 enables the tick clock.
  - The divider counts only when both bits are 1.
  - The divider produces one tick every `div` reference cycles, where `div` is control bits 17:0. A `div` of 0 is treated as 1.
- R3: The tick counter advances on a tick only when control bits 18, 24 and 25 are all 1. It stops and holds at the terminal count.
- R4: A write of any data to offset 0xC clears the tick counter to zero.
- R5: When the tick counter equals the terminal count, counting is enabled and control bit 21 is 1, `sys_rst_req` rises on the next clock. It then stays high until bit 18 or bit 25 is cleared, or until the block is reset.
- R6: With control bit 21 at 0, expiry never raises `sys_rst_req`. Writing 0 to the control word drops `sys_rst_req` one cycle later and keeps it low.
- R7: Clearing control bit 18 or bit 25 clears both the divider and the tick counter, so the tick count reads zero.
- R8: Register reads work as follows:
  - Offsets 0x0, 0x4 and 0x8 return the value last written. Only bits 25, 24, 21, 18 and 17:0 of the control word are stored. The terminal count stores `TCNT_W` bits.
  - Offset 0xC returns the tick count.
  - Unused bits read 0.
  - Read data is registered, so it is valid one cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Byte address; bits 3:2 select the register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| sys_rst_req | output | 1 | Registered system reset request |

## Verification
The bench builds the block with its default parameters: an 18-bit divider field and a 16-bit terminal count. It programs small divider values from 1 to 5 and terminal counts up to about 20. With these values, the bench reaches full expiries, restarts right at the boundary, and repeated enable and disable cycles within a few hundred clocks. Random register writes and kicks are checked against a cycle model of the prescaler and counter that is kept in the bench.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DIV_W   = 18;
  localparam int BIT_WDEN  = 18;
  localparam int BIT_RSTEN = 21;
  localparam int BIT_CLKEN = 24;
  localparam int BIT_DIVEN = 25;
  localparam logic [1:0] REG_CTRL  = 2'd0;
  localparam logic [1:0] REG_SPARE = 2'd1;
  localparam logic [1:0] REG_TERM  = 2'd2;
  localparam logic [1:0] REG_KICK  = 2'd3;
  typedef struct packed {
    logic             div_en;
    logic             clk_en;
    logic             rst_en;
    logic             wd_en;
    logic [DIV_W-1:0] div;
  } ctrl_t;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int DIV_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             clear,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] last;
  assign last = (div == '0) ? '0 : div - 1'b1;
  assign tick = run && (cnt >= last);

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (run) cnt <= (cnt >= last) ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int TCNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              kick,
  input  logic              tick,
  input  logic              count_en,
  input  logic [TCNT_W-1:0] term,
  output logic [TCNT_W-1:0] count,
  output logic              expired
);
  assign expired = count_en && (count >= term);

  always_ff @(posedge clk) begin
    if (rst || clear || kick) count <= '0;
    else if (count_en && tick && count < term) count <= count + 1'b1;
  end
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int TCNT_W = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [3:0]  addr,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        sys_rst_req
);
  localparam int SPARE_W = 32;

  ctrl_t              ctrl_q;
  logic [SPARE_W-1:0] spare_q;
  logic [TCNT_W-1:0]  term_q;
  logic [TCNT_W-1:0]  count;
  logic [1:0]         sel;
  logic               kick, tick, expired, pre_run, cnt_en, halt;

  assign sel     = addr[3:2];
  assign kick    = wr_en && sel == REG_KICK;
  assign pre_run = ctrl_q.div_en && ctrl_q.clk_en;
  assign cnt_en  = pre_run && ctrl_q.wd_en;
  assign halt    = !(ctrl_q.div_en && ctrl_q.wd_en);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      spare_q <= '0;
      term_q  <= '0;
    end else if (wr_en) begin
      case (sel)
        REG_CTRL: begin
          ctrl_q.div_en <= wr_data[BIT_DIVEN];
          ctrl_q.clk_en <= wr_data[BIT_CLKEN];
          ctrl_q.rst_en <= wr_data[BIT_RSTEN];
          ctrl_q.wd_en  <= wr_data[BIT_WDEN];
          ctrl_q.div    <= wr_data[DIV_W-1:0];
        end
        REG_SPARE: spare_q <= wr_data;
        REG_TERM:  term_q  <= wr_data[TCNT_W-1:0];
        default: ;
      endcase
    end
  end

  wdog_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst(rst), .run(pre_run), .clear(halt),
    .div(ctrl_q.div), .tick(tick)
  );

  wdog_counter #(.TCNT_W(TCNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clear(halt), .kick(kick), .tick(tick),
    .count_en(cnt_en), .term(term_q), .count(count), .expired(expired)
  );

  always_ff @(posedge clk) begin
    if (rst || halt) sys_rst_req <= 1'b0;
    else if (expired && ctrl_q.rst_en) sys_rst_req <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) begin
      rd_data <= '0;
      case (sel)
        REG_CTRL: begin
          rd_data[BIT_DIVEN]   <= ctrl_q.div_en;
          rd_data[BIT_CLKEN]   <= ctrl_q.clk_en;
          rd_data[BIT_RSTEN]   <= ctrl_q.rst_en;
          rd_data[BIT_WDEN]    <= ctrl_q.wd_en;
          rd_data[DIV_W-1:0]   <= ctrl_q.div;
        end
        REG_SPARE: rd_data <= spare_q;
        REG_TERM:  rd_data[TCNT_W-1:0] <= term_q;
        default:   rd_data[TCNT_W-1:0] <= count;
      endcase
    end
  end
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
  parameter int TCNT_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              sys_rst_req,
  input logic              expired,
  input logic              halt,
  input logic              kick,
  input logic              tick,
  input logic              pre_run,
  input logic              rst_en,
  input logic [TCNT_W-1:0] count,
  input logic [TCNT_W-1:0] term
);
  // R5: expiry with reset allowed raises the request next cycle
  a_r5_raise: assert property (@(posedge clk) disable iff (rst)
    (expired && rst_en && !halt) |=> sys_rst_req);
  // R6: request drops after a disable
  a_r6_drop: assert property (@(posedge clk) disable iff (rst)
    halt |=> !sys_rst_req);
  // R4: a kick clears the count
  a_r4_kick: assert property (@(posedge clk) disable iff (rst)
    kick |=> count == '0);
  // R3: the count never passes the terminal value
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    $stable(term) |-> count <= term || count == '0 || $past(count) > term);
  // R2: no tick while the prescaler is stopped
  a_r2_no_tick: assert property (@(posedge clk) disable iff (rst)
    !pre_run |-> !tick);
  // R7: a disable clears the count
  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    halt |=> count == '0);
endmodule

bind wdog_top wdog_checker #(.TCNT_W(TCNT_W)) u_chk (
  .clk(clk), .rst(rst), .sys_rst_req(sys_rst_req), .expired(expired),
  .halt(halt), .kick(kick), .tick(tick), .pre_run(pre_run),
  .rst_en(ctrl_q.rst_en), .count(count), .term(term_q)
);

// File: tb/test_wdog_top.sv
module test_wdog_top;
  logic        clk = 0;
  logic        rst;
  logic        wr_en, rd_en;
  logic [3:0]  addr;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        sys_rst_req;
  int checks = 0, fails = 0;
  bit done = 0;

  wdog_top i_wdog_top (.*);

  always #10 clk = ~clk;

  // model state
  logic [31:0] m_ctrl, m_spare;
  logic [15:0] m_term, m_cnt;
  logic [17:0] m_div;
  logic        m_req;

  function automatic logic [31:0] ctrl_mask(input logic [31:0] v);
    return v & 32'h0324_0000 | (v & 32'h0003_FFFF);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // model advances one clock with the bus inputs sampled at that edge
  task automatic model_step(input logic w, input logic [1:0] s, input logic [31:0] d);
    logic de, ce, we, re, halt, run, tk;
    logic [17:0] last;
    de = m_ctrl[25]; ce = m_ctrl[24]; we = m_ctrl[18]; re = m_ctrl[21];
    halt = !(de && we);
    run = de && ce;
    last = (m_ctrl[17:0] == 0) ? 0 : m_ctrl[17:0] - 1;
    tk = run && (m_div >= last);
    if (halt) m_req = 0;
    else if (run && we && m_cnt >= m_term && re) m_req = 1;
    if (halt || (w && s == 3)) m_cnt = 0;
    else if (run && we && tk && m_cnt < m_term) m_cnt = m_cnt + 1;
    if (halt) m_div = 0;
    else if (run) m_div = tk ? 0 : m_div + 1;
    if (w) case (s)
      0: m_ctrl = ctrl_mask(d);
      1: m_spare = d;
      2: m_term = d[15:0];
      default: ;
    endcase
  endtask

  task automatic cyc(input logic w, input logic [1:0] s, input logic [31:0] d);
    wr_en = w; rd_en = 0; addr = {s, 2'b00}; wr_data = d;
    @(posedge clk);
    model_step(w, s, d);
    #1 wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] s, input string req);
    logic [31:0] e;
    rd_en = 1; addr = {s, 2'b00};
    case (s)
      0: e = m_ctrl; 1: e = m_spare; 2: e = {16'h0, m_term}; default: e = {16'h0, m_cnt};
    endcase
    @(posedge clk);
    model_step(0, 0, 0);
    #1 rd_en = 0;
    check(req, rd_data, e);
    check(req, {31'b0, sys_rst_req}, {31'b0, m_req});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      cyc(0, 0, 0);
      checks++;
      if (sys_rst_req !== m_req) begin
        fails++;
        $display("FAIL R5: actual %b expected %b", sys_rst_req, m_req);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run hung, actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    wr_en = 0; rd_en = 0; addr = 0; wr_data = 0; rst = 1;
    m_ctrl = 0; m_spare = 0; m_term = 0; m_cnt = 0; m_div = 0; m_req = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1 reset state
    rd(0, "R1"); rd(1, "R1"); rd(2, "R1"); rd(3, "R1");
    // R8 readback with unused bits
    cyc(1, 0, 32'hFFFF_FFFF); rd(0, "R8");
    cyc(1, 1, 32'hA5A5_5A5A); rd(1, "R8");
    cyc(1, 2, 32'hDEAD_0007); rd(2, "R8");
    cyc(1, 0, 0);
    // R2/R3/R5 full expiry, div=3, term=5
    cyc(1, 2, 5);
    cyc(1, 0, 32'h0324_0003);
    idle(25); rd(3, "R3"); rd(0, "R5");
    // R6 disable drops request
    cyc(1, 0, 0); idle(2); rd(3, "R6");
    // R7 clearing bit 18 only
    cyc(1, 0, 32'h0304_0002); idle(7); rd(3, "R7 counting");
    cyc(1, 0, 32'h0300_0002); rd(3, "R7");
    // R6 no request when bit 21 clear
    cyc(1, 2, 3); cyc(1, 0, 32'h0304_0001); idle(20); rd(3, "R6 gated");
    // R2 clock-enable off freezes count
    cyc(1, 0, 32'h0204_0001); idle(5); rd(3, "R2 frozen");
    // R4 kick near boundary
    cyc(1, 0, 0); cyc(1, 2, 6); cyc(1, 0, 32'h0324_0002);
    idle(10); cyc(1, 3, 32'h1234_5678); rd(3, "R4");
    idle(3); cyc(1, 3, 0); idle(12); rd(3, "R4 boundary");
    // random mix
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r == 0) cyc(1, 0, ($urandom_range(0, 1) ? 32'h0324_0000 : 32'h0304_0000) |
                            ($urandom_range(0, 1) << 24) | $urandom_range(0, 5));
      else if (r == 1) cyc(1, 2, $urandom_range(0, 20));
      else if (r == 2) cyc(1, 3, $urandom);
      else if (r == 3) rd(3, "R3 random");
      else if (r == 4) cyc(1, 0, 0);
      else idle(1);
    end
    rd(0, "R8 random"); rd(2, "R8 random");
    // R1 synchronous reset mid-run
    rst = 1; @(posedge clk); #1 rst = 0;
    m_ctrl = 0; m_spare = 0; m_term = 0; m_cnt = 0; m_div = 0; m_req = 0;
    rd(0, "R1 rerun"); rd(3, "R1 rerun");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule